// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block is a two-address configuration port for an I/O controller. A host bus sees one index address and one data address, picked by a single select bit. The port is locked after reset. Two index writes of the unlock key, one straight after the other, open it. An index write of the lock key closes it again. While the port is open, an index write records a register number. Later data-address accesses then read or write that register.

The register space has two parts. The first part is global and lies below index 0x30. It holds a logical-device select, the identification registers (device ID, revision, vendor ID) and four multi-function pin-select registers. The second part starts at index 0x30 and is banked: the logical-device select decides which device bank answers. Each bank keeps its own enable register at 0x30 and drives the enable line of its device. Indexes above 0x30 are passed to the device logic outside this block. The block gives that logic a one-cycle write strobe or read strobe per bank, plus the register number and the write data. The device returns its read data on a per-bank byte input in the same cycle.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is locked. `cfg_mode` is 0, `dev_enable` is all zero, the four pin-select registers are 0, the logical-device select is 0, and `bus_rdata` holds 0xFF.
- R2: Two index writes of 0x87 in consecutive bus writes open the port. `cfg_mode` goes to 1 in the cycle after the second write.
- R3: Any bus write between the two keys resets the unlock sequence, and so does an index value other than 0x87. The port then stays locked.
- R4: An index write of 0xAA while the port is open locks it in the next cycle and clears the latched index to 0x00.
- R5: While the port is locked, writes to the data address change nothing and pulse no strobe, index writes other than the keys latch nothing, and reads of either address return 0xFF.
- R6: While the port is open, an index write latches the register number, and an index read returns it. Read data is registered: it appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read.
- R7: Register 0x07 is the logical-device select. It reads back the value written, and it picks bank N for all indexes at or above 0x30.
- R8: Register 0x30 of the selected bank is a full read/write byte. Its bit 0 drives `dev_enable[N]`, and each bank keeps its own copy.
- R9: Indexes 0x20/0x21 read DEVICE_ID high/low byte, 0x22 reads REVISION, and 0x23/0x24 read VENDOR_ID high/low byte (default 0x1934). Writes to these indexes are ignored.
- R10: Indexes 0x27, 0x29, 0x2A and 0x2B are read/write pin-select registers, driven out on `pin_sel` slots 0..3 (slot k in bits 8k+7:8k). They are shared across all logical-device select values.
- R11: With a valid selected bank N and a latched index above 0x30, a data write asserts only `dev_wr_stb[N]` for that cycle, and a data read asserts only `dev_rd_stb[N]`. In both cases `dev_reg_idx` carries the index and `dev_wdata` carries the bus byte. The read returns `dev_rdata[8N+7:8N]`.
- R12: If the logical-device select is not below NUM_DEV, accesses at or above 0x30 pulse no strobe, change no enable, and read 0xFF. Global indexes with no register also read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Bus write, one cycle per access |
| bus_rd | input | 1 | Bus read, one cycle per access; ignored while bus_wr is high |
| bus_sel | input | 1 | 0 = index address, 1 = data address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| cfg_mode | output | 1 | Port is unlocked |
| dev_enable | output | NUM_DEV | Bit 0 of each bank's enable register |
| pin_sel | output | 32 | Four pin-select registers, slot k at bits 8k+7:8k |
| dev_reg_idx | output | 8 | Latched register number for device logic |
| dev_wdata | output | 8 | Write byte for device logic |
| dev_wr_stb | output | NUM_DEV | Per-bank write strobe |
| dev_rd_stb | output | NUM_DEV | Per-bank read strobe |
| dev_rdata | input | NUM_DEV*8 | Per-bank read data, bank N at bits 8N+7:8N |

## Verification
The unlock state machine is the main risk. If it holds the wrong state, the port opens early or fails to open, and this is visible on `cfg_mode` one cycle after the deciding index write. It also shows in the next data read as 0xFF where a register value was expected, or the reverse. A wrong latched index or bank select gives a wrong `bus_rdata` one cycle after the read, or a strobe on the wrong bank in the same cycle as the access. A lost enable bit shows on `dev_enable` in the cycle after the write.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      KS_LOCKED = 2'd0,
      KS_HALF   = 2'd1,
      KS_OPEN   = 2'd2
   } key_state_e;

   localparam logic [7:0] IDX_LDN      = 8'h07;
   localparam logic [7:0] IDX_DEVID_HI = 8'h20;
   localparam logic [7:0] IDX_DEVID_LO = 8'h21;
   localparam logic [7:0] IDX_REV      = 8'h22;
   localparam logic [7:0] IDX_VEND_HI  = 8'h23;
   localparam logic [7:0] IDX_VEND_LO  = 8'h24;
   localparam logic [7:0] IDX_BANK_EN  = 8'h30;

   localparam int PINSEL_COUNT = 4;

   // register number of pin-select slot m
   function automatic logic [7:0] pinsel_index(input int m);
      case (m)
         0:       pinsel_index = 8'h27;
         1:       pinsel_index = 8'h29;
         2:       pinsel_index = 8'h2A;
         default: pinsel_index = 8'h2B;
      endcase
   endfunction

endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
   import keyed_cfg_pkg::*;
#(
   parameter logic [7:0] UNLOCK_KEY = 8'h87,
   parameter logic [7:0] LOCK_KEY   = 8'hAA
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic       dat_wr,
   input  logic [7:0] wdata,
   output logic       open_o,
   output logic       closing_o
);

   key_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         KS_LOCKED: if (idx_wr && wdata == UNLOCK_KEY) st_d = KS_HALF;
         KS_HALF: begin
            if (idx_wr)      st_d = (wdata == UNLOCK_KEY) ? KS_OPEN : KS_LOCKED;
            else if (dat_wr) st_d = KS_LOCKED;
         end
         KS_OPEN:   if (idx_wr && wdata == LOCK_KEY) st_d = KS_LOCKED;
         default:   st_d = KS_LOCKED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= KS_LOCKED;
      else        st_q <= st_d;
   end

   assign open_o    = (st_q == KS_OPEN);
   assign closing_o = (st_q == KS_OPEN) && (st_d == KS_LOCKED);

endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
   import keyed_cfg_pkg::*;
#(
   parameter logic [15:0] DEVICE_ID = 16'h0A37,
   parameter logic [7:0]  REVISION  = 8'h05,
   parameter logic [15:0] VENDOR_ID = 16'h1934
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [7:0]                  idx,
   input  logic [7:0]                  wdata,
   output logic [7:0]                  ldn_o,
   output logic [PINSEL_COUNT*8-1:0]   pinsel_o,
   output logic                        rd_hit,
   output logic [7:0]                  rd_val
);

   logic [7:0] ldn_q;
   logic [7:0] ps_q [PINSEL_COUNT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        ldn_q <= '0;
      else if (wr_en && idx == IDX_LDN)  ldn_q <= wdata;
   end

   for (genvar m = 0; m < PINSEL_COUNT; m++) begin : g_pinsel
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                ps_q[m] <= '0;
         else if (wr_en && idx == pinsel_index(m))  ps_q[m] <= wdata;
      end
      assign pinsel_o[m*8 +: 8] = ps_q[m];
   end

   always_comb begin
      rd_hit = 1'b1;
      rd_val = 8'hFF;
      case (idx)
         IDX_LDN:      rd_val = ldn_q;
         IDX_DEVID_HI: rd_val = DEVICE_ID[15:8];
         IDX_DEVID_LO: rd_val = DEVICE_ID[7:0];
         IDX_REV:      rd_val = REVISION;
         IDX_VEND_HI:  rd_val = VENDOR_ID[15:8];
         IDX_VEND_LO:  rd_val = VENDOR_ID[7:0];
         default: begin
            rd_hit = 1'b0;
            for (int m = 0; m < PINSEL_COUNT; m++) begin
               if (idx == pinsel_index(m)) begin
                  rd_hit = 1'b1;
                  rd_val = ps_q[m];
               end
            end
         end
      endcase
   end

   assign ldn_o = ldn_q;

endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
   import keyed_cfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel,
   input  logic       acc_wr,
   input  logic       acc_rd,
   input  logic [7:0] idx,
   input  logic [7:0] wdata,
   input  logic [7:0] ext_rdata,
   output logic       enable_o,
   output logic       wr_stb,
   output logic       rd_stb,
   output logic [7:0] rd_val
);

   logic [7:0] en_q;
   logic       is_en_reg;
   logic       is_ext;

   assign is_en_reg = (idx == IDX_BANK_EN);
   assign is_ext    = (idx > IDX_BANK_EN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          en_q <= '0;
      else if (sel && acc_wr && is_en_reg) en_q <= wdata;
   end

   assign wr_stb   = sel && acc_wr && is_ext;
   assign rd_stb   = sel && acc_rd && is_ext;
   assign rd_val   = is_en_reg ? en_q : ext_rdata;
   assign enable_o = en_q[0];

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
   import keyed_cfg_pkg::*;
#(
   parameter int          NUM_DEV    = 4,
   parameter logic [7:0]  UNLOCK_KEY = 8'h87,
   parameter logic [7:0]  LOCK_KEY   = 8'hAA,
   parameter logic [15:0] DEVICE_ID  = 16'h0A37,
   parameter logic [7:0]  REVISION   = 8'h05,
   parameter logic [15:0] VENDOR_ID  = 16'h1934
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_wr,
   input  logic                        bus_rd,
   input  logic                        bus_sel,
   input  logic [7:0]                  bus_wdata,
   output logic [7:0]                  bus_rdata,
   output logic                        cfg_mode,
   output logic [NUM_DEV-1:0]          dev_enable,
   output logic [PINSEL_COUNT*8-1:0]   pin_sel,
   output logic [7:0]                  dev_reg_idx,
   output logic [7:0]                  dev_wdata,
   output logic [NUM_DEV-1:0]          dev_wr_stb,
   output logic [NUM_DEV-1:0]          dev_rd_stb,
   input  logic [NUM_DEV*8-1:0]        dev_rdata
);

   localparam logic [7:0] BANK_LIMIT = 8'(NUM_DEV);

   if (NUM_DEV < 1 || NUM_DEV > 255) begin : g_bad_num_dev
      $error("keyed_cfg_port: NUM_DEV must lie in 1..255");
   end
   if (UNLOCK_KEY == LOCK_KEY) begin : g_bad_keys
      $error("keyed_cfg_port: unlock and lock keys must differ");
   end

   logic       idx_wr, dat_wr, idx_rd, dat_rd;
   logic       open, closing;
   logic [7:0] index_q;
   logic [7:0] ldn;
   logic       bank_ok;
   logic       g_wr_en, acc_wr, acc_rd, in_bank_space;
   logic       g_hit;
   logic [7:0] g_val;
   logic [7:0] bank_val [NUM_DEV];
   logic [7:0] sel_bank_val;
   logic [7:0] rd_next;

   assign idx_wr = bus_wr && !bus_sel;
   assign dat_wr = bus_wr &&  bus_sel;
   assign idx_rd = bus_rd && !bus_wr && !bus_sel;
   assign dat_rd = bus_rd && !bus_wr &&  bus_sel;

   cfg_key_fsm #(
      .UNLOCK_KEY (UNLOCK_KEY),
      .LOCK_KEY   (LOCK_KEY)
   ) u_key (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx_wr    (idx_wr),
      .dat_wr    (dat_wr),
      .wdata     (bus_wdata),
      .open_o    (open),
      .closing_o (closing)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                index_q <= '0;
      else if (closing)          index_q <= '0;
      else if (open && idx_wr)   index_q <= bus_wdata;
   end

   assign in_bank_space = (index_q >= IDX_BANK_EN);
   assign g_wr_en       = open && dat_wr && !in_bank_space;
   assign acc_wr        = open && dat_wr &&  in_bank_space;
   assign acc_rd        = open && dat_rd &&  in_bank_space;

   cfg_global_regs #(
      .DEVICE_ID (DEVICE_ID),
      .REVISION  (REVISION),
      .VENDOR_ID (VENDOR_ID)
   ) u_glob (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (g_wr_en),
      .idx      (index_q),
      .wdata    (bus_wdata),
      .ldn_o    (ldn),
      .pinsel_o (pin_sel),
      .rd_hit   (g_hit),
      .rd_val   (g_val)
   );

   assign bank_ok = (ldn < BANK_LIMIT);

   for (genvar b = 0; b < NUM_DEV; b++) begin : g_bank
      cfg_dev_bank u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .sel       (ldn == 8'(b)),
         .acc_wr    (acc_wr),
         .acc_rd    (acc_rd),
         .idx       (index_q),
         .wdata     (bus_wdata),
         .ext_rdata (dev_rdata[b*8 +: 8]),
         .enable_o  (dev_enable[b]),
         .wr_stb    (dev_wr_stb[b]),
         .rd_stb    (dev_rd_stb[b]),
         .rd_val    (bank_val[b])
      );
   end

   always_comb begin
      sel_bank_val = 8'hFF;
      for (int b = 0; b < NUM_DEV; b++) begin
         if (ldn == 8'(b)) sel_bank_val = bank_val[b];
      end
   end

   always_comb begin
      rd_next = 8'hFF;
      if (open) begin
         if (!bus_sel)           rd_next = index_q;
         else if (in_bank_space) rd_next = bank_ok ? sel_bank_val : 8'hFF;
         else if (g_hit)         rd_next = g_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                bus_rdata <= 8'hFF;
      else if (idx_rd || dat_rd) bus_rdata <= rd_next;
   end

   assign cfg_mode    = open;
   assign dev_reg_idx = index_q;
   assign dev_wdata   = bus_wdata;

endmodule

// File: rtl/keyed_cfg_port_chk.sv
module keyed_cfg_port_chk #(
   parameter int         NUM_DEV    = 4,
   parameter logic [7:0] UNLOCK_KEY = 8'h87,
   parameter logic [7:0] LOCK_KEY   = 8'hAA
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic               bus_rd,
   input logic               bus_sel,
   input logic [7:0]         bus_wdata,
   input logic [7:0]         bus_rdata,
   input logic               cfg_mode,
   input logic [NUM_DEV-1:0] dev_enable,
   input logic [7:0]         dev_reg_idx,
   input logic [NUM_DEV-1:0] dev_wr_stb,
   input logic [NUM_DEV-1:0] dev_rd_stb
);

   // R2
   unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_mode) |-> $past(bus_wr && !bus_sel && bus_wdata == UNLOCK_KEY));

   // R4
   lock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode && bus_wr && !bus_sel && bus_wdata == LOCK_KEY) |=> !cfg_mode);

   // R5
   locked_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_mode |-> (dev_wr_stb == '0 && dev_rd_stb == '0));

   // R5
   locked_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_mode && bus_rd && !bus_wr) |=> bus_rdata == 8'hFF);

   // R8
   enable_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dev_enable) |-> $past(bus_wr && bus_sel && cfg_mode));

   // R11
   one_wr_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_wr_stb) && $onehot0(dev_rd_stb));

   // R11
   stb_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_wr_stb != '0 || dev_rd_stb != '0) |-> dev_reg_idx > 8'h30);

endmodule

bind keyed_cfg_port keyed_cfg_port_chk #(
   .NUM_DEV    (NUM_DEV),
   .UNLOCK_KEY (UNLOCK_KEY),
   .LOCK_KEY   (LOCK_KEY)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr      (bus_wr),
   .bus_rd      (bus_rd),
   .bus_sel     (bus_sel),
   .bus_wdata   (bus_wdata),
   .bus_rdata   (bus_rdata),
   .cfg_mode    (cfg_mode),
   .dev_enable  (dev_enable),
   .dev_reg_idx (dev_reg_idx),
   .dev_wr_stb  (dev_wr_stb),
   .dev_rd_stb  (dev_rd_stb)
);

// File: tb/tb_keyed_cfg_port.sv
module tb_keyed_cfg_port;

   localparam int ND = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
   logic [7:0]    bus_wdata = '0;
   logic [7:0]    bus_rdata;
   logic          cfg_mode;
   logic [ND-1:0] dev_enable;
   logic [31:0]   pin_sel;
   logic [7:0]    dev_reg_idx, dev_wdata;
   logic [ND-1:0] dev_wr_stb, dev_rd_stb;
   logic [ND*8-1:0] dev_rdata;

   int checks = 0;
   int errors = 0;
   logic          done = 1'b0;

   logic [ND-1:0] seen_wr, seen_rd;
   logic [7:0]    seen_idx, seen_wd;

   always #2 clk = ~clk;

   // device model: bank b answers index ^ (0x40 + b)
   always_comb begin
      for (int b = 0; b < ND; b++) dev_rdata[b*8 +: 8] = dev_reg_idx ^ 8'(8'h40 + b);
   end

   keyed_cfg_port #(.NUM_DEV(ND)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cfg_mode(cfg_mode), .dev_enable(dev_enable), .pin_sel(pin_sel),
      .dev_reg_idx(dev_reg_idx), .dev_wdata(dev_wdata),
      .dev_wr_stb(dev_wr_stb), .dev_rd_stb(dev_rd_stb), .dev_rdata(dev_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] v);
      @(negedge clk);
      bus_sel = sel; bus_wdata = v; bus_wr = 1'b1;
      #1;
      seen_wr = dev_wr_stb; seen_rd = dev_rd_stb;
      seen_idx = dev_reg_idx; seen_wd = dev_wdata;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic sel, output logic [7:0] v);
      @(negedge clk);
      bus_sel = sel; bus_rd = 1'b1;
      #1;
      seen_wr = dev_wr_stb; seen_rd = dev_rd_stb;
      @(negedge clk);
      bus_rd = 1'b0;
      v = bus_rdata;
   endtask

   task automatic reg_wr(input logic [7:0] idx, input logic [7:0] v);
      wr(1'b0, idx); wr(1'b1, v);
   endtask

   task automatic reg_rd(input logic [7:0] idx, output logic [7:0] v);
      wr(1'b0, idx); rd(1'b1, v);
   endtask

   task automatic unlock();
      wr(1'b0, 8'h87); wr(1'b0, 8'h87);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R1 cfg_mode", cfg_mode, 0);
      chk("R1 dev_enable", dev_enable, 0);
      chk("R1 pin_sel", pin_sel, 0);
      chk("R1 rdata", bus_rdata, 8'hFF);
      rd(1'b1, v);
      chk("R1/R5 locked data read", v, 8'hFF);
   endtask

   task automatic t_locked();
      logic [7:0] v;
      wr(1'b0, 8'h30);
      wr(1'b1, 8'h01);
      chk("R5 no strobe while locked", {seen_wr, seen_rd}, 0);
      chk("R5 enable untouched", dev_enable, 0);
      rd(1'b0, v);
      chk("R5 locked index read", v, 8'hFF);
      unlock();
      rd(1'b0, v);
      chk("R5 index not latched when locked", v, 8'h00);
      wr(1'b0, 8'hAA);
   endtask

   task automatic t_unlock();
      wr(1'b0, 8'h87);
      chk("R2 one key keeps locked", cfg_mode, 0);
      wr(1'b0, 8'h87);
      chk("R2 two keys open", cfg_mode, 1);
   endtask

   task automatic t_interrupt();
      wr(1'b0, 8'hAA);
      wr(1'b0, 8'h87); wr(1'b0, 8'h55); wr(1'b0, 8'h87);
      chk("R3 other index value resets", cfg_mode, 0);
      wr(1'b0, 8'hAA);
      wr(1'b0, 8'h87); wr(1'b1, 8'h87); wr(1'b0, 8'h87);
      chk("R3 data write resets", cfg_mode, 0);
      wr(1'b0, 8'h87);
      chk("R3 fresh pair after reset opens", cfg_mode, 1);
   endtask

   task automatic t_index();
      logic [7:0] v;
      wr(1'b0, 8'h5A);
      rd(1'b0, v);
      chk("R6 index readback", v, 8'h5A);
      rd(1'b0, v);
      chk("R6 rdata repeat", v, 8'h5A);
   endtask

   task automatic t_ids();
      logic [7:0] v;
      reg_rd(8'h20, v); chk("R9 devid hi", v, 8'h0A);
      reg_rd(8'h21, v); chk("R9 devid lo", v, 8'h37);
      reg_rd(8'h22, v); chk("R9 revision", v, 8'h05);
      reg_rd(8'h23, v); chk("R9 vendor hi", v, 8'h19);
      reg_rd(8'h24, v); chk("R9 vendor lo", v, 8'h34);
      reg_wr(8'h20, 8'hEE);
      reg_rd(8'h20, v); chk("R9 id write ignored", v, 8'h0A);
   endtask

   task automatic t_pinsel();
      logic [7:0] v;
      reg_wr(8'h27, 8'hA5); reg_wr(8'h29, 8'h3C);
      reg_wr(8'h2A, 8'h0F); reg_wr(8'h2B, 8'hF0);
      reg_wr(8'h07, 8'h02);
      reg_rd(8'h29, v); chk("R10 pin-select readback", v, 8'h3C);
      chk("R10 pin_sel outputs", pin_sel, 32'hF00F3CA5);
      reg_wr(8'h07, 8'h00);
      reg_rd(8'h2B, v); chk("R10 shared across select", v, 8'hF0);
   endtask

   task automatic t_banks();
      logic [7:0] v;
      reg_wr(8'h07, 8'h01); reg_wr(8'h30, 8'h01);
      chk("R8 bank1 enable", dev_enable, 4'b0010);
      reg_wr(8'h07, 8'h03); reg_wr(8'h30, 8'h81);
      chk("R8 bank3 enable", dev_enable, 4'b1010);
      reg_rd(8'h30, v); chk("R8 bank3 readback", v, 8'h81);
      reg_wr(8'h07, 8'h01);
      reg_rd(8'h30, v); chk("R7 select routes to bank1", v, 8'h01);
      reg_rd(8'h07, v); chk("R7 select readback", v, 8'h01);
   endtask

   task automatic t_dev();
      logic [7:0] v;
      reg_wr(8'h07, 8'h02);
      reg_wr(8'h45, 8'h9C);
      chk("R11 write strobe bank2", seen_wr, 4'b0100);
      chk("R11 strobe index", seen_idx, 8'h45);
      chk("R11 strobe data", seen_wd, 8'h9C);
      chk("R11 no read strobe on write", seen_rd, 0);
      rd(1'b1, v);
      chk("R11 read strobe bank2", seen_rd, 4'b0100);
      chk("R11 device read data", v, 8'h07);
   endtask

   task automatic t_badldn();
      logic [7:0] v;
      reg_wr(8'h07, 8'h09);
      reg_wr(8'h30, 8'h01);
      chk("R12 no enable change", dev_enable, 4'b1010);
      rd(1'b1, v); chk("R12 bank read FF", v, 8'hFF);
      reg_wr(8'h50, 8'h11);
      chk("R12 no write strobe", seen_wr, 0);
      rd(1'b1, v);
      chk("R12 no read strobe", seen_rd, 0);
      chk("R12 ext read FF", v, 8'hFF);
      reg_rd(8'h10, v); chk("R12 unmapped global FF", v, 8'hFF);
   endtask

   task automatic t_lock();
      logic [7:0] v;
      wr(1'b0, 8'h44);
      wr(1'b0, 8'hAA);
      chk("R4 lock key closes", cfg_mode, 0);
      rd(1'b1, v); chk("R4 read after lock FF", v, 8'hFF);
      unlock();
      rd(1'b0, v); chk("R4 index cleared", v, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_locked();
      t_unlock();
      t_interrupt();
      t_index();
      t_ids();
      t_pinsel();
      t_banks();
      t_dev();
      t_badldn();
      t_lock();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule